// File: doc/BRIEF.md
# Privilege-Aliased Interrupt Register Aperture

This block is the register file of a core-local interrupt controller. It stores one global configuration byte and, for every interrupt input, a pending flag, an enable flag, an attribute byte and a control byte. The storage exists once. It is reachable through up to three address windows, one for each privilege level: machine, supervisor and user. Each window applies its own access filter. Because of this, software at a lower privilege level can get a window of its own through ordinary memory protection, and the interconnect never carries the initiator's privilege level.

The bus is 32 bits wide and word addressed, with a byte strobe. Each interrupt occupies one word, with one register in each byte lane. Reads are combinational from the address. Writes take effect at the clock edge. Each interrupt also has a pending-set input driven by hardware. The owner mode of an interrupt sits in its attribute byte. A window shows an interrupt only when the window's privilege is at least that of the owner.

Top module: `clic_aperture_regs`

## Requirements
- R1: Through the machine window (address bits [15:13] = 0), every register of every interrupt can be read and written, whatever its owner mode.
- R2: Through the supervisor window (bits [15:13] = 1), a machine-owned interrupt reads as all zeros, and writes to it change nothing.
- R3: Through the user window (bits [15:13] = 2), interrupts owned by machine or supervisor read zero and ignore writes. User-owned interrupts are fully accessible.
- R4: The configuration byte is in lane 0 of word offset 0x000 in every window. Only the machine window can write it. The supervisor and user windows read its value, and their writes are dropped.
- R5: All windows alias one set of storage. A write through one window is visible through every other window allowed to see it, from the next cycle on.
- R6: When parameter USER_EN is 0, the user window is not decoded. Its reads return zero and its writes are dropped.
- R7: Bits [7:6] of the attribute byte give the owner mode: 11 machine, 01 supervisor, 00 user, and 10 is treated as machine. A write that would set the owner to a mode above the writing window's privilege keeps the old owner field and updates the rest of the byte.
- R8: Interrupt i is at window offset 0x1000 + 4*i. Lane 0 bit 0 holds pending, lane 1 bit 0 holds enable, lane 2 holds attribute and lane 3 holds control. Only lanes with their strobe bit set are written. Unused bits read zero.
- R9: A one-cycle pulse on irq_set[i] sets pending. A permitted write of 0 clears it. A hardware set in the same cycle as a software clear wins.
- R10: Reads return zero and writes are ignored for: interrupt indices at or above NUM_IRQ, offsets outside the configuration word and the interrupt area, and window number 3 or above.
- R11: After reset, the configuration byte is 0. Every interrupt has pending and enable at 0, control at 0, and attribute 0xC0 (machine owned).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte lane strobe for writes |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_set | input | NUM_IRQ | Per-interrupt pending-set pulse |

## Verification
The same interrupt words are accessed in turn through the machine, supervisor and user windows while the owner mode moves among machine, supervisor, user and the reserved code. This tells apart a filter keyed on the window from one keyed on the owner, and it shows whether the window or the stored mode governs writes to the owner field. Partial strobes, all-ones write data and addresses just past the last interrupt or inside the unused fourth window separate lane decoding from index bounds checking. A second instance built without the user window shows that the window is truly absent. A pending set that collides with a software clear fixes which of the two takes priority.

// File: rtl/clic_ap_pkg.sv
package clic_ap_pkg;

    localparam int IDX_W = 10;   // interrupt index field width inside a window
    localparam int OFF_W = 13;   // window size is 2**OFF_W bytes

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_R = 2'b10,
        PRIV_M = 2'b11
    } priv_e;

    typedef struct packed {
        logic             cfg_hit;
        logic             irq_hit;
        priv_e            ap;
        logic [IDX_W-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic [7:0] ctl;
        logic [7:0] attr;
        logic       ie;
        logic       pend;
    } irq_view_t;

    // reserved owner code ranks with machine
    function automatic logic [1:0] rank(input logic [1:0] m);
        return (m == 2'b10) ? 2'b11 : m;
    endfunction

    function automatic logic may_access(input logic [1:0] ap, input logic [1:0] owner);
        return rank(owner) <= rank(ap);
    endfunction

    function automatic logic [31:0] pack_word(input irq_view_t v);
        return {v.ctl, v.attr, 7'b0, v.ie, 7'b0, v.pend};
    endfunction

endpackage

// File: rtl/clic_ap_decode.sv
module clic_ap_decode
    import clic_ap_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_IRQ = 8,
    parameter bit USER_EN = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int AP_W = ADDR_W - OFF_W;
    localparam logic [IDX_W:0] IDX_LIM = (IDX_W+1)'(NUM_IRQ);

    logic [AP_W-1:0]  ap_sel;
    logic [OFF_W-1:0] off;
    logic             ap_ok;
    logic             unused_lsb;

    assign ap_sel     = addr[ADDR_W-1:OFF_W];
    assign off        = addr[OFF_W-1:0];
    assign unused_lsb = ^addr[1:0];

    always_comb begin
        dec    = '0;
        dec.ap = PRIV_U;
        ap_ok  = 1'b0;
        if (ap_sel == AP_W'(0)) begin
            dec.ap = PRIV_M;
            ap_ok  = 1'b1;
        end else if (ap_sel == AP_W'(1)) begin
            dec.ap = PRIV_S;
            ap_ok  = 1'b1;
        end else if (USER_EN && ap_sel == AP_W'(2)) begin
            dec.ap = PRIV_U;
            ap_ok  = 1'b1;
        end
        dec.idx     = off[IDX_W+1:2];
        dec.cfg_hit = ap_ok && (off[OFF_W-1:2] == '0);
        dec.irq_hit = ap_ok && off[OFF_W-1] && ({1'b0, off[IDX_W+1:2]} < IDX_LIM);
    end

endmodule

// File: rtl/clic_ap_slot.sv
module clic_ap_slot
    import clic_ap_pkg::*;
#(
    parameter logic [7:0] ATTR_RST = 8'hC0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        set_in,
    input  logic        sel,
    input  priv_e       ap,
    input  logic [31:0] wdata,
    input  logic [3:0]  wstrb,
    output irq_view_t   view
);
    logic       pend_q, ie_q;
    logic [7:0] attr_q, ctl_q;
    logic       acc_ok;
    logic [7:0] attr_new;
    logic       unused_bits;

    assign unused_bits = ^{wdata[7:1], wdata[15:9]};
    assign acc_ok      = sel && may_access(ap, attr_q[7:6]);

    always_comb begin
        attr_new = wdata[23:16];
        if (!may_access(ap, wdata[23:22]))
            attr_new[7:6] = attr_q[7:6];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            ie_q   <= 1'b0;
            attr_q <= ATTR_RST;
            ctl_q  <= 8'h00;
        end else begin
            if (set_in)
                pend_q <= 1'b1;
            else if (acc_ok && wstrb[0])
                pend_q <= wdata[0];
            if (acc_ok && wstrb[1]) ie_q   <= wdata[8];
            if (acc_ok && wstrb[2]) attr_q <= attr_new;
            if (acc_ok && wstrb[3]) ctl_q  <= wdata[31:24];
        end
    end

    assign view = '{ctl: ctl_q, attr: attr_q, ie: ie_q, pend: pend_q};

    // R9: hardware set always lands
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        set_in |=> pend_q);

    // R2 / R3: a hidden interrupt keeps its software-visible state
    p_drop_hidden_r2: assert property (@(posedge clk) disable iff (rst)
        (sel && !may_access(ap, attr_q[7:6]))
        |=> ($stable(attr_q) && $stable(ctl_q) && $stable(ie_q)));

    // R7: a lower window never raises the owner above itself
    p_mode_guard_r7: assert property (@(posedge clk) disable iff (rst)
        (sel && ap != PRIV_M)
        |=> (rank(attr_q[7:6]) <= rank($past(ap)) || $stable(attr_q[7:6])));

endmodule

// File: rtl/clic_ap_cfg.sv
module clic_ap_cfg
    import clic_ap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  priv_e      ap,
    input  logic [7:0] wdata,
    input  logic       wstrb0,
    output logic [7:0] cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= 8'h00;
        else if (sel && wstrb0 && ap == PRIV_M)
            cfg_q <= wdata;
    end

    // R4: only the machine window can change configuration
    p_cfg_ro_r4: assert property (@(posedge clk) disable iff (rst)
        (sel && ap != PRIV_M) |=> $stable(cfg_q));

endmodule

// File: rtl/clic_aperture_regs.sv
module clic_aperture_regs
    import clic_ap_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int ADDR_W  = 16,
    parameter bit USER_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    input  logic [3:0]         bus_wstrb,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_set
);
    dec_t         dec;
    irq_view_t    views [NUM_IRQ];
    irq_view_t    sel_view;
    logic [NUM_IRQ-1:0] slot_sel;
    logic [7:0]   cfg_q;

    clic_ap_decode #(
        .ADDR_W (ADDR_W),
        .NUM_IRQ(NUM_IRQ),
        .USER_EN(USER_EN)
    ) u_dec (
        .addr(bus_addr),
        .dec (dec)
    );

    clic_ap_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .sel   (bus_we && dec.cfg_hit),
        .ap    (dec.ap),
        .wdata (bus_wdata[7:0]),
        .wstrb0(bus_wstrb[0]),
        .cfg_q (cfg_q)
    );

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_slot
        assign slot_sel[g] = bus_we && dec.irq_hit && (dec.idx == IDX_W'(g));
        clic_ap_slot u_slot (
            .clk   (clk),
            .rst   (rst),
            .set_in(irq_set[g]),
            .sel   (slot_sel[g]),
            .ap    (dec.ap),
            .wdata (bus_wdata),
            .wstrb (bus_wstrb),
            .view  (views[g])
        );
    end

    always_comb begin
        sel_view = '0;
        for (int k = 0; k < NUM_IRQ; k++)
            if (dec.idx == IDX_W'(k)) sel_view = views[k];
    end

    always_comb begin
        bus_rdata = '0;
        if (dec.cfg_hit)
            bus_rdata = {24'b0, cfg_q};
        else if (dec.irq_hit && may_access(dec.ap, sel_view.attr[7:6]))
            bus_rdata = pack_word(sel_view);
    end

    // R2: machine-owned interrupts read zero in the supervisor window
    p_hide_m_r2: assert property (@(posedge clk) disable iff (rst)
        (dec.irq_hit && dec.ap == PRIV_S && sel_view.attr[7:6] == 2'b11)
        |-> bus_rdata == '0);

    // R3: only user-owned interrupts show in the user window
    p_hide_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (dec.irq_hit && dec.ap == PRIV_U && sel_view.attr[7:6] != 2'b00)
        |-> bus_rdata == '0);

    // R10: indices past the last interrupt read zero
    p_range_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[OFF_W-1] && ({1'b0, bus_addr[IDX_W+1:2]} >= (IDX_W+1)'(NUM_IRQ)))
        |-> bus_rdata == '0);

    if (!USER_EN) begin : g_no_user
        // R6: the user window is absent
        p_no_user_r6: assert property (@(posedge clk) disable iff (rst)
            (bus_addr[ADDR_W-1:OFF_W] == (ADDR_W-OFF_W)'(2)) |-> bus_rdata == '0);
    end

endmodule

// File: tb/clic_aperture_regs_tb.sv
`timescale 1ns/1ps
module clic_aperture_regs_tb_top;

    localparam int NUM_IRQ = 8;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 43;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h1000, 32'h0, 4'h0, 32'h00C00000, 8'd11}, // R11 reset owner machine
        '{1'b0, 16'h3000, 32'h0, 4'h0, 32'h00000000, 8'd2},  // R2
        '{1'b0, 16'h0000, 32'h0, 4'h0, 32'h00000000, 8'd11}, // R11 cfg reset
        '{1'b1, 16'h1000, 32'h55C00101, 4'hF, 32'h0, 8'd1},  // R1
        '{1'b0, 16'h1000, 32'h0, 4'h0, 32'h55C00101, 8'd1},  // R1
        '{1'b0, 16'h3000, 32'h0, 4'h0, 32'h00000000, 8'd2},  // R2
        '{1'b1, 16'h3000, 32'h00000000, 4'hF, 32'h0, 8'd2},  // R2 dropped
        '{1'b0, 16'h1000, 32'h0, 4'h0, 32'h55C00101, 8'd2},  // R2
        '{1'b1, 16'h1004, 32'h22410001, 4'hF, 32'h0, 8'd1},  // R1 owner S
        '{1'b0, 16'h3004, 32'h0, 4'h0, 32'h22410001, 8'd5},  // R5 alias
        '{1'b0, 16'h5004, 32'h0, 4'h0, 32'h00000000, 8'd3},  // R3
        '{1'b1, 16'h3004, 32'h33410100, 4'hF, 32'h0, 8'd9},  // R9 sw clear
        '{1'b0, 16'h1004, 32'h0, 4'h0, 32'h33410100, 8'd9},  // R9
        '{1'b1, 16'h3004, 32'h00C00000, 4'h4, 32'h0, 8'd7},  // R7 raise refused
        '{1'b0, 16'h1004, 32'h0, 4'h0, 32'h33400100, 8'd7},  // R7
        '{1'b1, 16'h3004, 32'h00000000, 4'h4, 32'h0, 8'd7},  // R7 lower to U
        '{1'b0, 16'h5004, 32'h0, 4'h0, 32'h33000100, 8'd3},  // R3 user owned
        '{1'b1, 16'h5004, 32'h00400000, 4'h4, 32'h0, 8'd7},  // R7 U raise refused
        '{1'b0, 16'h5004, 32'h0, 4'h0, 32'h33000100, 8'd7},  // R7
        '{1'b1, 16'h5004, 32'h77000000, 4'h8, 32'h0, 8'd8},  // R8 lane 3 only
        '{1'b0, 16'h1004, 32'h0, 4'h0, 32'h77000100, 8'd8},  // R8
        '{1'b1, 16'h0000, 32'h000000A5, 4'h1, 32'h0, 8'd4},  // R4
        '{1'b0, 16'h2000, 32'h0, 4'h0, 32'h000000A5, 8'd4},  // R4
        '{1'b1, 16'h2000, 32'h0000003C, 4'h1, 32'h0, 8'd4},  // R4 S write dropped
        '{1'b0, 16'h0000, 32'h0, 4'h0, 32'h000000A5, 8'd4},  // R4
        '{1'b1, 16'h4000, 32'h0000003C, 4'h1, 32'h0, 8'd4},  // R4 U write dropped
        '{1'b0, 16'h4000, 32'h0, 4'h0, 32'h000000A5, 8'd4},  // R4
        '{1'b1, 16'h0000, 32'hFFFFFF5A, 4'hF, 32'h0, 8'd8},  // R8
        '{1'b0, 16'h0000, 32'h0, 4'h0, 32'h0000005A, 8'd8},  // R8 unused bits zero
        '{1'b1, 16'h1020, 32'hFFFFFFFF, 4'hF, 32'h0, 8'd10}, // R10 index 8
        '{1'b0, 16'h1020, 32'h0, 4'h0, 32'h00000000, 8'd10}, // R10
        '{1'b0, 16'h101C, 32'h0, 4'h0, 32'h00C00000, 8'd10}, // R10 last index intact
        '{1'b0, 16'h0800, 32'h0, 4'h0, 32'h00000000, 8'd10}, // R10 hole
        '{1'b1, 16'h7000, 32'hFFFFFFFF, 4'hF, 32'h0, 8'd10}, // R10 window 3
        '{1'b0, 16'h7000, 32'h0, 4'h0, 32'h00000000, 8'd10}, // R10
        '{1'b0, 16'h1000, 32'h0, 4'h0, 32'h55C00101, 8'd10}, // R10 no wrap into irq0
        '{1'b1, 16'h1008, 32'h00800000, 4'h4, 32'h0, 8'd7},  // R7 reserved code
        '{1'b0, 16'h3008, 32'h0, 4'h0, 32'h00000000, 8'd7},  // R7 acts as machine
        '{1'b0, 16'h1008, 32'h0, 4'h0, 32'h00800000, 8'd1},  // R1
        '{1'b1, 16'h100C, 32'h000000FF, 4'h1, 32'h0, 8'd8},  // R8
        '{1'b0, 16'h100C, 32'h0, 4'h0, 32'h00C00001, 8'd8},  // R8
        '{1'b1, 16'h0000, 32'h000000EE, 4'h2, 32'h0, 8'd8},  // R8 lane 0 not strobed
        '{1'b0, 16'h0000, 32'h0, 4'h0, 32'h0000005A, 8'd8}   // R8
    };

    logic               clk = 1'b0;
    logic               rst;
    logic [15:0]        bus_addr;
    logic               bus_we;
    logic [31:0]        bus_wdata;
    logic [3:0]         bus_wstrb;
    logic [31:0]        rdata_a, rdata_b;
    logic [NUM_IRQ-1:0] irq_set;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    clic_aperture_regs #(.NUM_IRQ(NUM_IRQ), .ADDR_W(16), .USER_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(rdata_a),
        .irq_set(irq_set)
    );

    clic_aperture_regs #(.NUM_IRQ(NUM_IRQ), .ADDR_W(16), .USER_EN(1'b0)) dut_nou_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(rdata_b),
        .irq_set(irq_set)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wstrb = 4'h0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [31:0] ra, output logic [31:0] rb);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1;
        ra = rdata_a;
        rb = rdata_b;
    endtask

    initial begin
        logic [31:0] ra, rb;
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_wstrb = '0; irq_set = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int n = 0; n < NV; n++) begin
            if (VEC[n].wr) begin
                do_write(VEC[n].addr, VEC[n].data, VEC[n].strb);
            end else begin
                do_read(VEC[n].addr, ra, rb);
                check($sformatf("R%0d vec%0d", VEC[n].req, n), ra, VEC[n].exp);
            end
        end

        // R9: hardware pulse sets pending
        @(negedge clk); irq_set = 8'h10;
        @(negedge clk); irq_set = '0;
        do_read(16'h1010, ra, rb);
        check("R9 pulse", ra, 32'h00C00001);
        do_write(16'h1010, 32'h0, 4'h1);
        do_read(16'h1010, ra, rb);
        check("R9 clear", ra, 32'h00C00000);
        // R9: set and clear collide, set wins
        @(negedge clk);
        irq_set = 8'h10; bus_addr = 16'h1010; bus_wdata = 32'h0; bus_wstrb = 4'h1; bus_we = 1'b1;
        @(negedge clk);
        irq_set = '0; bus_we = 1'b0; bus_wstrb = 4'h0;
        do_read(16'h1010, ra, rb);
        check("R9 set wins", ra, 32'h00C00001);

        // R6 with R3: user window present in one build, absent in the other
        do_write(16'h1000, 32'h00000101, 4'hF);
        do_read(16'h5000, ra, rb);
        check("R3 user visible", ra, 32'h00000101);
        check("R6 user absent read", rb, 32'h00000000);
        do_write(16'h5000, 32'h00000000, 4'hF);
        do_read(16'h1000, ra, rb);
        check("R3 user write", ra, 32'h00000000);
        check("R6 user absent write", rb, 32'h00000101);
        do_read(16'h3000, ra, rb);
        check("R6 supervisor kept", rb, 32'h00000101);

        // R11: reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        do_read(16'h1004, ra, rb);
        check("R11 irq after reset", ra, 32'h00C00000);
        do_read(16'h0000, ra, rb);
        check("R11 cfg after reset", ra, 32'h00000000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule